// File: doc/BRIEF.md
# Bridge Switch Fault Latch Controller

This block guards the four power switches of a two-leg bridge: a high-side and a low-side switch on leg A, and the same pair on leg B. Each switch supplies a digitised over-current flag and an over-temperature flag. An over-current flag that stays high for a programmable number of consecutive clock cycles latches that switch off. The latch stays set until a timed pulse arrives on the direction input of the switch's own leg. No separate clear pin exists. A high-side latch needs a falling pulse, and a low-side latch needs a rising pulse. The over-temperature flag is a level. It masks the switch only while it is asserted and never latches.

The sense-select input chooses which leg the shared current-sense path reports. When any switch of the chosen leg is latched or over temperature, the block asks the sense path to drive its fault-high level in place of the proportional current. The enable mask is meant to gate the gate-drive logic downstream.

Each switch runs its own state machine with four states. `SW_ARMED` is idle with no fault. `SW_QUALIFY` counts consecutive over-current cycles. `SW_LATCHED` holds the switch off. `SW_RELEASE` counts the clearing pulse. The named transitions are:
- *qualify-start*: ARMED to QUALIFY when the flag is seen high.
- *qualify-drop*: QUALIFY to ARMED when the flag is seen low.
- *trip*: QUALIFY to LATCHED when the count is complete.
- *pulse-start*: LATCHED to RELEASE when the leg input moves onto the clearing level.
- *pulse-short*: RELEASE to LATCHED when the input leaves that level early.
- *clear*: RELEASE to ARMED when the pulse count is complete.

Top module: `bridge_fault_latch`

## Requirements
- R1: A switch whose over-current flag is sampled high on QUAL_CYCLES consecutive rising edges is latched off. Its enable bit goes low right after the QUAL_CYCLES-th of those edges, and the other three enable bits are unaffected. Enable bit order is [0] leg-A high side, [1] leg-A low side, [2] leg-B high side, [3] leg-B low side.
- R2: Any edge at which the over-current flag is sampled low restarts the consecutive count from zero.
- R3: A latched switch stays off after its over-current flag returns low, until a valid clearing pulse arrives.
- R4: A latched high-side switch (bits 0 and 2) is cleared by its leg's direction input (dir_a for leg A, dir_b for leg B) moving from 1 to 0 and being sampled 0 on RESET_MIN consecutive edges. Its enable returns right after the RESET_MIN-th such edge.
- R5: A latched low-side switch (bits 1 and 3) is cleared in the same way by its leg's direction input moving from 0 to 1 and being sampled 1 on RESET_MIN consecutive edges.
- R6: A clearing pulse that leaves the clearing level before RESET_MIN samples leaves the switch latched.
- R7: If the over-current flag is still high when the latch clears, qualification restarts from zero. The switch latches again QUAL_CYCLES edges after the clear edge.
- R8: An asserted over-temperature flag drops that switch's enable in the same cycle, with no clock. The enable returns as soon as the flag drops, with no latching, however long the flag was held.
- R9: sense_fault_hi is high exactly when the selected leg has a switch that is latched or over temperature. sense_sel=1 selects leg A (bits 0 and 1), and sense_sel=0 selects leg B (bits 2 and 3). It follows sense_sel with no clock.
- R10: After reset, all four enable bits are 1, no switch is latched, and sense_fault_hi is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Leg A direction input, also carries leg A clearing pulses |
| dir_b | input | 1 | Leg B direction input, also carries leg B clearing pulses |
| sense_sel | input | 1 | Sense leg select: 1 = leg A, 0 = leg B |
| oc_flag | input | 4 | Per-switch over-current flags |
| ot_flag | input | 4 | Per-switch over-temperature level flags |
| sw_enable | output | 4 | Per-switch enable mask, 1 = switch may conduct |
| sense_fault_hi | output | 1 | Request to force the sense output to its fault-high level |

## Verification
The bench targets the counter boundaries. It drops the over-current flag for one cycle one edge short of tripping: a filter that integrates instead of restarting would trip early. It sends a clearing pulse one sample short: a design that is off by one in the release count would unlatch. It holds the fault through a valid clear to confirm the relatch lands exactly QUAL_CYCLES edges later, which a design that skipped the restart or kept a stale count would miss. It also toggles sense_sel under a one-leg fault and holds an over-temperature flag past the trip time. These catch a swapped leg mapping and any latching of the thermal flag.

// File: rtl/bfl_pkg.sv
`timescale 1ns/1ps
package bfl_pkg;

    typedef enum logic [1:0] {
        SW_ARMED    = 2'd0,
        SW_QUALIFY  = 2'd1,
        SW_LATCHED  = 2'd2,
        SW_RELEASE  = 2'd3
    } sw_state_e;

    localparam int NUM_SW = 4;

    // Odd indices are low-side switches; they clear on a rising pulse.
    function automatic bit sw_clear_level(int idx);
        return (idx % 2) == 1;
    endfunction

    // Indices 0 and 1 belong to leg A.
    function automatic bit sw_on_leg_a(int idx);
        return idx < 2;
    endfunction

endpackage

// File: rtl/bfl_switch_fsm.sv
`timescale 1ns/1ps
module bfl_switch_fsm
    import bfl_pkg::*;
#(
    parameter int QUAL_CYCLES = 250,
    parameter int RESET_MIN   = 150,
    parameter bit CLEAR_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic ot_flag,
    input  logic dir_in,
    output logic sw_enable,
    output logic sw_fault
);

    localparam int CNT_MAX = (QUAL_CYCLES > RESET_MIN) ? QUAL_CYCLES : RESET_MIN;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] QUAL_LAST = CW'(QUAL_CYCLES - 1);
    localparam logic [CW-1:0] REL_LAST  = CW'(RESET_MIN - 1);

    sw_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          dir_q;
    logic          at_clear, pulse_start, latched;

    assign at_clear    = (dir_in == CLEAR_LEVEL);
    assign pulse_start = at_clear && (dir_q != CLEAR_LEVEL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_ARMED;
            cnt_q   <= '0;
            dir_q   <= CLEAR_LEVEL;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            dir_q   <= dir_in;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SW_ARMED: begin
                cnt_d = '0;
                if (oc_flag) begin
                    if (QUAL_CYCLES <= 1) begin
                        state_d = SW_LATCHED;           // trip
                    end else begin
                        state_d = SW_QUALIFY;           // qualify-start
                        cnt_d   = CW'(1);
                    end
                end
            end
            SW_QUALIFY: begin
                if (!oc_flag) begin
                    state_d = SW_ARMED;                 // qualify-drop
                    cnt_d   = '0;
                end else if (cnt_q == QUAL_LAST) begin
                    state_d = SW_LATCHED;               // trip
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            SW_LATCHED: begin
                cnt_d = '0;
                if (pulse_start) begin
                    if (RESET_MIN <= 1) begin
                        state_d = SW_ARMED;             // clear
                    end else begin
                        state_d = SW_RELEASE;           // pulse-start
                        cnt_d   = CW'(1);
                    end
                end
            end
            SW_RELEASE: begin
                if (!at_clear) begin
                    state_d = SW_LATCHED;               // pulse-short
                    cnt_d   = '0;
                end else if (cnt_q == REL_LAST) begin
                    state_d = SW_ARMED;                 // clear
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        latched   = (state_q == SW_LATCHED) || (state_q == SW_RELEASE);
        sw_fault  = latched || ot_flag;
        sw_enable = !sw_fault;
    end

endmodule

// File: rtl/bfl_sense_route.sv
`timescale 1ns/1ps
module bfl_sense_route
    import bfl_pkg::*;
(
    input  logic              sense_sel,
    input  logic [NUM_SW-1:0] sw_fault,
    output logic              fault_hi
);

    logic leg_a_fault, leg_b_fault;

    always_comb begin
        leg_a_fault = 1'b0;
        leg_b_fault = 1'b0;
        for (int i = 0; i < NUM_SW; i++) begin
            if (sw_on_leg_a(i)) leg_a_fault = leg_a_fault | sw_fault[i];
            else                leg_b_fault = leg_b_fault | sw_fault[i];
        end
        fault_hi = sense_sel ? leg_a_fault : leg_b_fault;
    end

endmodule

// File: rtl/bridge_fault_latch.sv
`timescale 1ns/1ps
module bridge_fault_latch
    import bfl_pkg::*;
#(
    parameter int QUAL_CYCLES = 250,
    parameter int RESET_MIN   = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_a,
    input  logic              dir_b,
    input  logic              sense_sel,
    input  logic [NUM_SW-1:0] oc_flag,
    input  logic [NUM_SW-1:0] ot_flag,
    output logic [NUM_SW-1:0] sw_enable,
    output logic              sense_fault_hi
);

    logic [NUM_SW-1:0] sw_fault;

    for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
        localparam bit LVL = sw_clear_level(i);
        localparam bit LEG_A = sw_on_leg_a(i);
        bfl_switch_fsm #(
            .QUAL_CYCLES (QUAL_CYCLES),
            .RESET_MIN   (RESET_MIN),
            .CLEAR_LEVEL (LVL)
        ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .oc_flag   (oc_flag[i]),
            .ot_flag   (ot_flag[i]),
            .dir_in    (LEG_A ? dir_a : dir_b),
            .sw_enable (sw_enable[i]),
            .sw_fault  (sw_fault[i])
        );
    end

    bfl_sense_route u_route (
        .sense_sel (sense_sel),
        .sw_fault  (sw_fault),
        .fault_hi  (sense_fault_hi)
    );

endmodule

// File: rtl/bfl_checker.sv
`timescale 1ns/1ps
module bfl_checker
    import bfl_pkg::*;
#(
    parameter int QUAL_CYCLES = 250,
    parameter int RESET_MIN   = 150
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir_a,
    input logic              dir_b,
    input logic              sense_sel,
    input logic [NUM_SW-1:0] oc_flag,
    input logic [NUM_SW-1:0] ot_flag,
    input logic [NUM_SW-1:0] sw_enable,
    input logic              sense_fault_hi
);

    localparam int RW = $clog2(((QUAL_CYCLES > RESET_MIN) ? QUAL_CYCLES : RESET_MIN) + 2);

    for (genvar i = 0; i < NUM_SW; i++) begin : g_chk
        localparam bit LVL = sw_clear_level(i);
        localparam bit LEG_A = sw_on_leg_a(i);
        logic          at_clr;
        logic [RW-1:0] oc_run, clr_run;

        assign at_clr = ((LEG_A ? dir_a : dir_b) == LVL);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                oc_run  <= '0;
                clr_run <= '0;
            end else begin
                if (!oc_flag[i])                      oc_run <= '0;
                else if (oc_run < RW'(QUAL_CYCLES))   oc_run <= oc_run + RW'(1);
                if (!at_clr)                          clr_run <= '0;
                else if (clr_run < RW'(RESET_MIN))    clr_run <= clr_run + RW'(1);
            end
        end

        // R1, R2: a trip needs a full run of consecutive flag samples
        a_r2_persist: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(sw_enable[i]) && !ot_flag[i]) |-> (oc_run >= RW'(QUAL_CYCLES)));

        // R1: enable only falls for an over-current sample or over-temperature
        a_r1_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sw_enable[i]) |-> (ot_flag[i] || $past(oc_flag[i])));

        // R4 and R5: a clear needs RESET_MIN samples at the clearing level
        a_r4_release_len: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(sw_enable[i]) && !$past(ot_flag[i])) |-> (clr_run >= RW'(RESET_MIN)));

        // R8: over-temperature masks the switch
        a_r8_ot_mask: assert property (@(posedge clk) disable iff (!rst_n)
            ot_flag[i] |-> !sw_enable[i]);
    end

    // R9: fault-high request tracks the selected leg
    a_r9_sense_leg: assert property (@(posedge clk) disable iff (!rst_n)
        sense_fault_hi == (sense_sel ? !(&sw_enable[1:0]) : !(&sw_enable[3:2])));

endmodule

bind bridge_fault_latch bfl_checker #(
    .QUAL_CYCLES (QUAL_CYCLES),
    .RESET_MIN   (RESET_MIN)
) u_bfl_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .dir_a          (dir_a),
    .dir_b          (dir_b),
    .sense_sel      (sense_sel),
    .oc_flag        (oc_flag),
    .ot_flag        (ot_flag),
    .sw_enable      (sw_enable),
    .sense_fault_hi (sense_fault_hi)
);

// File: tb/bridge_fault_latch_test.sv
`timescale 1ns/1ps
module bridge_fault_latch_test;

    localparam int QUAL = 250;
    localparam int RMIN = 150;

    typedef struct {
        int         cyc;
        logic [3:0] en;
        logic       fhi;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dir_a, dir_b, sense_sel;
    logic [3:0] oc_flag, ot_flag;
    logic [3:0] sw_enable;
    logic       sense_fault_hi;

    int        cyc = 0;
    int        n_checks = 0;
    int        n_fail = 0;
    bit        done = 1'b0;
    exp_item_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    bridge_fault_latch #(.QUAL_CYCLES(QUAL), .RESET_MIN(RMIN)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .dir_a          (dir_a),
        .dir_b          (dir_b),
        .sense_sel      (sense_sel),
        .oc_flag        (oc_flag),
        .ot_flag        (ot_flag),
        .sw_enable      (sw_enable),
        .sense_fault_hi (sense_fault_hi)
    );

    task automatic expect_at(int c, logic [3:0] e, logic f, string tag);
        exp_item_t it;
        it.cyc = c; it.en = e; it.fhi = f; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic expect_next(logic [3:0] e, logic f, string tag);
        expect_at(cyc + 1, e, f, tag);
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: compare 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
                exp_item_t it;
                it = exp_q.pop_front();
                n_checks++;
                if (it.cyc != cyc || sw_enable !== it.en || sense_fault_hi !== it.fhi) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: enable=%b fault_hi=%b expected enable=%b fault_hi=%b",
                             it.tag, cyc, sw_enable, sense_fault_hi, it.en, it.fhi);
                end
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        int n;
        rst_n = 1'b0; dir_a = 1'b0; dir_b = 1'b0; sense_sel = 1'b0;
        oc_flag = '0; ot_flag = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_next(4'b1111, 1'b0, "R10 reset state");

        // R2: one clean sample just before the trip edge restarts the filter
        @(negedge clk);
        dir_a = 1'b0; dir_b = 1'b1; sense_sel = 1'b1; oc_flag[1] = 1'b1;
        n = cyc;
        wait_to(n + QUAL - 1);
        oc_flag[1] = 1'b0;
        expect_next(4'b1111, 1'b0, "R2 filter restart");
        wait_to(n + QUAL);
        oc_flag[1] = 1'b1;
        n = cyc;
        expect_at(n + QUAL - 1, 4'b1111, 1'b0, "R1 not yet tripped");
        expect_at(n + QUAL, 4'b1101, 1'b1, "R1 trip only leg-A low side, R9 leg A");
        wait_to(n + QUAL + 1);
        oc_flag[1] = 1'b0;
        n = cyc;
        wait_to(n + 20);
        expect_next(4'b1101, 1'b1, "R3 latch holds");

        // R6: low-side pulse one sample short
        @(negedge clk);
        dir_a = 1'b1;
        n = cyc;
        wait_to(n + RMIN - 1);
        dir_a = 1'b0;
        wait_to(n + RMIN + 2);
        expect_next(4'b1101, 1'b1, "R6 short pulse ignored");

        // R5: full rising pulse clears the low-side latch
        @(negedge clk);
        dir_a = 1'b1;
        n = cyc;
        expect_at(n + RMIN - 1, 4'b1101, 1'b1, "R5 still latched");
        expect_at(n + RMIN, 4'b1111, 1'b0, "R5 cleared");
        wait_to(n + RMIN + 1);
        dir_a = 1'b0;

        // R4, R7: leg-B high side, fault held through the clear
        @(negedge clk);
        dir_a = 1'b1; sense_sel = 1'b0; oc_flag[2] = 1'b1;
        n = cyc;
        expect_at(n + QUAL, 4'b1011, 1'b1, "R1 leg-B high side trip");
        wait_to(n + QUAL + 1);
        dir_b = 1'b0;
        n = cyc;
        expect_at(n + RMIN - 1, 4'b1011, 1'b1, "R4 still latched");
        expect_at(n + RMIN, 4'b1111, 1'b0, "R4 cleared");
        expect_at(n + RMIN + QUAL - 1, 4'b1111, 1'b0, "R7 requalifying");
        expect_at(n + RMIN + QUAL, 4'b1011, 1'b1, "R7 relatched");
        wait_to(n + RMIN + QUAL + 1);
        oc_flag[2] = 1'b0;

        // R9: select follows immediately
        @(negedge clk);
        sense_sel = 1'b1;
        expect_next(4'b1011, 1'b0, "R9 leg A selected, no fault");
        repeat (2) @(negedge clk);
        sense_sel = 1'b0;
        expect_next(4'b1011, 1'b1, "R9 leg B selected, fault");

        // R8: thermal level, held past the trip time, never latches
        @(negedge clk);
        sense_sel = 1'b1; ot_flag[0] = 1'b1;
        expect_next(4'b1010, 1'b1, "R8 thermal mask");
        n = cyc;
        wait_to(n + QUAL + 5);
        ot_flag[0] = 1'b0;
        expect_next(4'b1011, 1'b0, "R8 thermal release");

        repeat (4) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule